// File: doc/BRIEF.md
# Microsecond Limit Timer Bank

This block is a bank of limit timers: one system-wide timer and one profiling timer for each of up to four processors. All of them advance on a shared 1 MHz tick-enable strobe. Each timer holds a count and a limit in the same bit field, from bit 10 up to bit 30. When the count reaches a nonzero limit, the timer reloads its count, sets a sticky reached flag in bit 31 and raises its interrupt line. The system timer's line goes to interrupt level 10. Each processor's line goes to level 14 of that processor.

Software programs a period by writing `(period_us + 1) << 10` into a limit word. It acknowledges an interrupt by reading that same limit word. A second limit address, the alias, changes the limit without restarting the count. A start/stop word for each processor and a configuration word for the system timer are plain storage. One reserved word always reads as zero.

Register access uses a simple 32-bit bus with separate write and read strobes. Read data is combinational from the address.

Top module: `lt_timer_bank`

## Requirements
- R1: After reset every limit, count, reached flag, start/stop word and the configuration word is zero, and both interrupt outputs are low.
- R2: A count changes only on a cycle with `tick_en` high. It appears in bits 30:10 of the count word (processor n at byte 0x10*n+0x4, system timer at 0x44). Bits 9:0 of every limit and count word read as zero, whatever was written.
- R3: On a tick where count+1 equals a nonzero limit, the count becomes 1, the reached flag (bit 31 of both the limit and the count word) is set, and the timer's interrupt goes high on the next cycle. After a limit write, the first interrupt therefore comes limit-1 ticks later.
- R4: A read of the limit word (processor n at 0x10*n, system timer at 0x40) clears that timer's reached flag and interrupt. A read of the count word or of the alias does not. If a new limit hit happens in the same cycle as the acknowledging read, the flag stays set.
- R5: A write to the limit word stores bits 30:10 as the limit, sets the count to 1 and clears the reached flag and interrupt.
- R6: A write to the alias (processor n at 0x10*n+0x8, system timer at 0x48) changes only the limit. The count and the reached flag keep their values.
- R7: With a limit of zero the timer never raises its interrupt. The count keeps increasing and wraps from all-ones to zero.
- R8: The system timer drives `irq_sys`, and processor timer n drives `irq_prof[n]`. Each timer's registers and interrupt are independent of the others.
- R9: The word at 0x4C reads as zero and ignores writes. The configuration word at 0x50 and each processor's start/stop word at 0x10*n+0xC hold the full 32-bit value last written.
- R10: When a limit write and a tick fall in the same cycle, the write takes effect and that timer ignores the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe at 1 MHz; advances every count |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of a limit word acknowledges |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_sys | output | 1 | System timer interrupt (level 10) |
| irq_prof | output | NUM_CPU | Per-processor profiling timer interrupts (level 14) |

## Verification
The bench targets the same-cycle collisions. One is a tick arriving with a limit write: a design that let the tick through would read back a count of 2 instead of 1. The other is an acknowledge read landing on the very cycle of a new hit: a design with the wrong priority would drop that interrupt.

It also checks that the alias leaves both the count and a pending flag in place; a design that shared the reset path would restart the period. It checks that count reads and alias reads leave the flag set, and that a zero limit stays silent over a hundred ticks. Register decoding is checked through the reserved word, the low ten bits, and the independence of the five timers.

// File: rtl/lt_pkg.sv
package lt_pkg;
    localparam int DATA_W    = 32;
    localparam int FIELD_LSB = 10;
    localparam int CNT_W     = DATA_W - 1 - FIELD_LSB;
    localparam int MAX_CPU   = 4;
    localparam int GLB_WORD  = 4 * MAX_CPU;
    localparam int GLB_WORDS = 5;

    typedef enum logic [2:0] {
        REG_LIMIT,
        REG_COUNT,
        REG_ALIAS,
        REG_AUX,
        REG_RSVD,
        REG_CFG,
        REG_NONE
    } reg_kind_e;

    function automatic logic [DATA_W-1:0] pack_word(input logic flag,
                                                    input logic [CNT_W-1:0] fld);
        return {flag, fld, {FIELD_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/lt_addr_decode.sv
module lt_addr_decode
    import lt_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output reg_kind_e         kind
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    int                gofs;

    always_comb begin
        word = addr[ADDR_W-1:2];
        gofs = int'(word) - GLB_WORD;
        idx  = '0;
        kind = REG_NONE;
        if (int'(word) < 4 * NUM_CPU) begin
            idx = IDX_W'(word >> 2);
            case (word[1:0])
                2'd0:    kind = REG_LIMIT;
                2'd1:    kind = REG_COUNT;
                2'd2:    kind = REG_ALIAS;
                default: kind = REG_AUX;
            endcase
        end else if (gofs >= 0 && gofs < GLB_WORDS) begin
            idx = IDX_W'(NUM_CPU);
            case (gofs)
                0:       kind = REG_LIMIT;
                1:       kind = REG_COUNT;
                2:       kind = REG_ALIAS;
                3:       kind = REG_RSVD;
                default: kind = REG_CFG;
            endcase
        end
    end
endmodule

// File: rtl/lt_timer_unit.sv
module lt_timer_unit
    import lt_pkg::*;
#(
    parameter int FLD_W = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_limit,
    input  logic             wr_alias,
    input  logic             rd_ack,
    input  logic [FLD_W-1:0] wr_field,
    output logic [FLD_W-1:0] lim_o,
    output logic [FLD_W-1:0] cnt_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [FLD_W-1:0] lim;
        logic [FLD_W-1:0] cnt;
        logic             hit;
    } tmr_st_t;

    localparam logic [FLD_W-1:0] ONE  = FLD_W'(1);
    localparam logic [FLD_W-1:0] FULL = '1;

    tmr_st_t          st_d, st_q;
    logic [FLD_W-1:0] inc_d;
    logic             reach_d;

    always_comb begin
        st_d    = st_q;
        inc_d   = st_q.cnt + ONE;
        reach_d = (st_q.lim != '0) && (inc_d == st_q.lim);
        if (wr_limit) begin
            st_d.lim = wr_field;
            st_d.cnt = ONE;
            st_d.hit = 1'b0;
        end else begin
            if (wr_alias) st_d.lim = wr_field;
            if (rd_ack)   st_d.hit = 1'b0;
            if (tick) begin
                if (reach_d) begin
                    st_d.cnt = ONE;
                    st_d.hit = 1'b1;
                end else begin
                    st_d.cnt = inc_d;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lim_o = st_q.lim;
    assign cnt_o = st_q.cnt;
    assign hit_o = st_q.hit;

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_limit) |=> $stable(st_q.cnt)); // R2
    AST_HIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_limit && st_q.lim != '0 && st_q.cnt == st_q.lim - ONE)
        |=> (st_q.cnt == ONE && st_q.hit)); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !tick) |=> !st_q.hit); // R4
    AST_LIMIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wr_limit |=> (st_q.cnt == ONE && !st_q.hit)); // R5
    AST_ALIAS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_alias && !wr_limit && !tick && !rd_ack) |=> ($stable(st_q.cnt) && $stable(st_q.hit))); // R6
    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lim == '0 && !st_q.hit && !wr_alias) |=> !st_q.hit); // R7
    AST_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_limit && st_q.lim == '0 && st_q.cnt == FULL) |=> (st_q.cnt == '0)); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_limit && tick) |=> (st_q.cnt == ONE)); // R10
endmodule

// File: rtl/lt_aux_regs.sv
module lt_aux_regs
    import lt_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_aux,
    input  logic                           wr_cfg,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DATA_W-1:0]              wdata,
    output logic [NUM_CPU-1:0][DATA_W-1:0] aux_o,
    output logic [DATA_W-1:0]              cfg_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0][DATA_W-1:0] aux;
        logic [DATA_W-1:0]              cfg;
    } aux_st_t;

    aux_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (wr_aux && int'(idx) == i) st_d.aux[i] = wdata;
        end
        if (wr_cfg) st_d.cfg = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign aux_o = st_q.aux;
    assign cfg_o = st_q.cfg;

    AST_CFG_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (cfg_o == $past(wdata))); // R9
    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable(cfg_o)); // R9
endmodule

// File: rtl/lt_timer_bank.sv
module lt_timer_bank
    import lt_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_sys,
    output logic [NUM_CPU-1:0] irq_prof
);
    localparam int NT    = NUM_CPU + 1;
    localparam int IDX_W = $clog2(NT);

    logic [IDX_W-1:0]               sel_idx;
    reg_kind_e                      sel_kind;
    logic [NT-1:0]                  wr_lim_s, wr_ali_s, rd_ack_s;
    logic [NT-1:0][CNT_W-1:0]       lim_a, cnt_a;
    logic [NT-1:0]                  hit_a;
    logic [NUM_CPU-1:0][DATA_W-1:0] aux_a;
    logic [DATA_W-1:0]              cfg_w;
    logic [CNT_W-1:0]               wfield;

    assign wfield = bus_wdata[DATA_W-2:FIELD_LSB];

    lt_addr_decode #(
        .NUM_CPU (NUM_CPU),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_dec (
        .addr (bus_addr),
        .idx  (sel_idx),
        .kind (sel_kind)
    );

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        assign wr_lim_s[t] = bus_wr && sel_kind == REG_LIMIT && int'(sel_idx) == t;
        assign wr_ali_s[t] = bus_wr && sel_kind == REG_ALIAS && int'(sel_idx) == t;
        assign rd_ack_s[t] = bus_rd && sel_kind == REG_LIMIT && int'(sel_idx) == t;

        lt_timer_unit #(
            .FLD_W (CNT_W)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_en),
            .wr_limit (wr_lim_s[t]),
            .wr_alias (wr_ali_s[t]),
            .rd_ack   (rd_ack_s[t]),
            .wr_field (wfield),
            .lim_o    (lim_a[t]),
            .cnt_o    (cnt_a[t]),
            .hit_o    (hit_a[t])
        );
    end

    lt_aux_regs #(
        .NUM_CPU (NUM_CPU),
        .IDX_W   (IDX_W)
    ) u_aux (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_aux (bus_wr && sel_kind == REG_AUX),
        .wr_cfg (bus_wr && sel_kind == REG_CFG),
        .idx    (sel_idx),
        .wdata  (bus_wdata),
        .aux_o  (aux_a),
        .cfg_o  (cfg_w)
    );

    always_comb begin
        bus_rdata = '0;
        for (int t = 0; t < NT; t++) begin
            if (int'(sel_idx) == t) begin
                case (sel_kind)
                    REG_LIMIT, REG_ALIAS: bus_rdata = pack_word(hit_a[t], lim_a[t]);
                    REG_COUNT:            bus_rdata = pack_word(hit_a[t], cnt_a[t]);
                    default:              ;
                endcase
            end
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            if (sel_kind == REG_AUX && int'(sel_idx) == c) bus_rdata = aux_a[c];
        end
        if (sel_kind == REG_CFG) bus_rdata = cfg_w;
    end

    assign irq_sys  = hit_a[NUM_CPU];
    assign irq_prof = hit_a[NUM_CPU-1:0];

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lim_s, wr_ali_s})); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_kind == REG_RSVD) |-> (bus_rdata == '0)); // R9
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_kind inside {REG_LIMIT, REG_COUNT, REG_ALIAS}) |-> (bus_rdata[FIELD_LSB-1:0] == '0)); // R2
endmodule

// File: tb/lt_timer_bank_bench.sv
module lt_timer_bank_bench;
    localparam int NCPU = 4;
    localparam int OP_WR = 0;
    localparam int OP_RD = 1;
    localparam int OP_TK = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h00, 32'h0000_1400, 32'h0, 4'd5},        // R5 cpu0 limit 5
        '{2'd1, 8'h04, 32'h0, 32'h0000_0400, 4'd5},        // R5 count restarts at 1
        '{2'd2, 8'h00, 32'd3, 32'h0, 4'd2},
        '{2'd1, 8'h04, 32'h0, 32'h0000_1000, 4'd2},        // R2 count 4
        '{2'd2, 8'h00, 32'd1, 32'h0, 4'd3},
        '{2'd1, 8'h04, 32'h0, 32'h8000_0400, 4'd3},        // R3 reload and flag
        '{2'd1, 8'h08, 32'h0, 32'h8000_1400, 4'd4},        // R4 alias read keeps flag
        '{2'd1, 8'h04, 32'h0, 32'h8000_0400, 4'd4},        // R4 count read keeps flag
        '{2'd1, 8'h00, 32'h0, 32'h8000_1400, 4'd4},        // R4 acknowledging read
        '{2'd1, 8'h04, 32'h0, 32'h0000_0400, 4'd4},        // R4 flag cleared
        '{2'd0, 8'h48, 32'h0000_3C00, 32'h0, 4'd6},        // R6 system alias
        '{2'd1, 8'h44, 32'h0, 32'h0000_1000, 4'd6},        // R6 count untouched
        '{2'd1, 8'h40, 32'h0, 32'h0000_3C00, 4'd6},        // R6 limit changed
        '{2'd1, 8'h14, 32'h0, 32'h0000_1000, 4'd8},        // R8 cpu1 independent
        '{2'd0, 8'h4C, 32'hFFFF_FFFF, 32'h0, 4'd9},
        '{2'd1, 8'h4C, 32'h0, 32'h0000_0000, 4'd9},        // R9 reserved reads zero
        '{2'd0, 8'h50, 32'hA5A5_0003, 32'h0, 4'd9},
        '{2'd1, 8'h50, 32'h0, 32'hA5A5_0003, 4'd9},        // R9 config stores
        '{2'd0, 8'h1C, 32'h8000_0001, 32'h0, 4'd9},
        '{2'd1, 8'h1C, 32'h0, 32'h8000_0001, 4'd9},        // R9 start/stop stores
        '{2'd0, 8'h20, 32'h0000_17FF, 32'h0, 4'd2},
        '{2'd1, 8'h20, 32'h0, 32'h0000_1400, 4'd2}         // R2 low bits read zero
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_sys;
    logic [NCPU-1:0] irq_prof;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lt_timer_bank #(.NUM_CPU(NCPU), .ADDR_W(8)) u_lt_timer_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_sys   (irq_sys),
        .irq_prof  (irq_prof)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick_en   = tk;
        @(negedge clk);
        bus_wr  = 1'b0;
        tick_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic tk, output logic [31:0] v);
        bus_addr = a;
        bus_rd   = 1'b1;
        tick_en  = tk;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd  = 1'b0;
        tick_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        do_rd(8'h04, 1'b0, v); check(v, 32'h0, "R1 cpu0 count");
        do_rd(8'h40, 1'b0, v); check(v, 32'h0, "R1 system limit");
        do_rd(8'h50, 1'b0, v); check(v, 32'h0, "R1 config");
        do_rd(8'h3C, 1'b0, v); check(v, 32'h0, "R1 cpu3 start/stop");
        check({27'd0, irq_sys, irq_prof}, 32'h0, "R1 interrupts low");

        for (int i = 0; i < NV; i++) begin
            case (int'(VEC[i].op))
                OP_WR: do_wr(VEC[i].addr, VEC[i].data, 1'b0);
                OP_RD: begin
                    do_rd(VEC[i].addr, 1'b0, v);
                    check(v, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
                end
                default: run_ticks(int'(VEC[i].data));
            endcase
        end

        // R10 limit write with a tick in the same cycle
        do_wr(8'h30, 32'h0000_2000, 1'b1);
        do_rd(8'h34, 1'b0, v); check(v, 32'h0000_0400, "R10 tick ignored on write");

        // R4 acknowledge colliding with a new hit
        do_wr(8'h20, 32'h0000_0C00, 1'b0);
        run_ticks(1);
        do_rd(8'h20, 1'b1, v);
        check({31'd0, irq_prof[2]}, 32'd1, "R4 hit wins over ack");
        do_rd(8'h24, 1'b0, v); check(v, 32'h8000_0400, "R4 flag after collision");
        do_rd(8'h20, 1'b0, v);
        check({31'd0, irq_prof[2]}, 32'd0, "R4 ack drops irq");

        // R8 system timer drives its own line
        do_wr(8'h40, 32'h0000_0C00, 1'b0);
        run_ticks(1);
        check({31'd0, irq_sys}, 32'd0, "R8 system irq before hit");
        run_ticks(1);
        check({31'd0, irq_sys}, 32'd1, "R8 system irq at hit");
        check({31'd0, irq_prof[3]}, 32'd0, "R8 cpu3 unaffected");

        // R6 alias write leaves a pending flag alone
        do_wr(8'h48, 32'h0001_0000, 1'b0);
        check({31'd0, irq_sys}, 32'd1, "R6 alias keeps irq");
        do_rd(8'h40, 1'b0, v); check(v, 32'h8001_0000, "R6 alias limit with flag");
        check({31'd0, irq_sys}, 32'd0, "R4 system ack");

        // R3 period after a limit write
        do_wr(8'h00, 32'h0000_1400, 1'b0);
        run_ticks(3);
        check({31'd0, irq_prof[0]}, 32'd0, "R3 no irq early");
        run_ticks(1);
        check({31'd0, irq_prof[0]}, 32'd1, "R3 irq after limit-1 ticks");

        // R7 zero limit free-runs without interrupt
        do_rd(8'h14, 1'b0, v1);
        run_ticks(100);
        do_rd(8'h14, 1'b0, v);
        check(v, v1 + (32'd100 << 10), "R7 free-running count");
        check({31'd0, irq_prof[1]}, 32'd0, "R7 no irq at zero limit");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule